// File: doc/BRIEF.md
# Multi-mode asynchronous serial port

This block is a full-duplex asynchronous serial port for a host controller. A small register bus gives the host three addresses. The data address is shared by both directions. A write to it loads a byte and starts a transmit frame at once. A read of it returns the last byte received, not the byte written. Transmit and receive run at the same time and do not depend on each other.

A two-bit mode field sets the frame format and the timing source. Mode 1 sends a start bit, eight data bits and a stop bit. Modes 2 and 3 add a ninth bit after the data, which can carry parity or user data. Modes 1 and 3 are timed by a 16x oversampling tick from an external rate source. Mode 2 runs at a fixed fraction of the system clock: 1/32 or 1/64, set by a doubling bit. Mode 0 turns the port off.

The receiver samples each bit at mid-bit and rejects short low pulses on an idle line. Sticky flags tell the host when a transmit is done, when a byte has arrived, and when a byte was lost.

Top module: `duplex_sport`

## Requirements
- R1: After reset, `txd` is high, the status register (address 2) reads 0 and the data address (address 0) reads 0.
- R2: In mode 1 (control bits [1:0] = 1) a frame is a low start bit, then eight data bits least significant bit first, then a high stop bit, each lasting 16 external ticks.
- R3: A write to address 0 starts transmission at once. A read of address 0 returns the receive buffer and never the transmitted byte.
- R4: In mode 3 the frame holds a ninth bit between the data and the stop bit. Its value is taken from control bit 4.
- R5: In mode 2 the bit period is 64 system clocks when control bit 2 (doubling) is 0, and 32 clocks when it is 1. The external tick is not used.
- R6: With control bit 3 set, the transmitter sends two stop bits. Status bit 4 (transmitter busy) stays 1 through the second stop bit. With the bit clear, busy drops after one stop bit.
- R7: Status bit 0 (transmit done) goes to 1 when the stop bit starts. It stays 1 until the host writes status with bit 0 set.
- R8: The receiver samples at mid-bit and captures a byte sent least significant bit first. Status bit 1 (receive full) goes to 1 at the middle of the stop bit and stays set until cleared by writing 1 to status bit 1. In modes 2 and 3 the received ninth bit is shown in status bit 3.
- R9: A low pulse on `rxd` shorter than half a bit does not start reception. Receive full stays 0, and a frame sent after it is received correctly.
- R10: If a byte completes while receive full is set, status bit 2 (overrun) is set and the buffer keeps the old byte. Writing 1 to status bit 2 clears overrun.
- R11: A frame can be sent and another received at the same time, and both are correct.
- R12: In mode 0 a write to address 0 starts nothing: `txd` stays high and busy stays 0.
- R13: A write to address 0 while the transmitter is busy is ignored. The frame in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 data, 1 control, 2 status |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| rate_tick16 | input | 1 | One-cycle pulse at 16x the bit rate, used in modes 1 and 3 |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |

## Verification
Most internal faults change what appears on `txd`. A wrong shift count, stop-bit count or ninth-bit select shows up as a wrong bit level within the frame it affects. A bad tick count or divider moves every later bit edge, so the mid-bit samples go wrong within one or two bit times. Receiver faults show up only at the next stop bit, as a wrong buffer byte or a wrong flag. A receiver stuck after a rejected glitch is caught when the following clean frame is not captured.

// File: rtl/sport_pkg.sv
package sport_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_8VAR = 2'd1,
    MODE_9FIX = 2'd2,
    MODE_9VAR = 2'd3
  } sp_mode_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
endpackage

// File: rtl/sport_tick.sv
module sport_tick #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       dbl,
  input  logic       ext_tick,
  output logic       tick
);
  import sport_pkg::*;
  localparam int DIV_FAST = 32 / OVS;
  localparam int DIV_SLOW = 64 / OVS;
  localparam int CW       = $clog2(DIV_SLOW + 1);

  logic [CW-1:0] cnt, cnt_n;
  logic [CW-1:0] lim;
  logic          fix_tick;

  assign lim      = dbl ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
  assign fix_tick = (cnt >= lim);

  always_comb begin
    cnt_n = fix_tick ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  always_comb begin
    case (sp_mode_e'(mode))
      MODE_9FIX: tick = fix_tick;
      MODE_OFF:  tick = 1'b0;
      default:   tick = ext_tick;
    endcase
  end
endmodule

// File: rtl/sport_tx.sv
module sport_tx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] data,
  input  logic          nine,
  input  logic          bit9,
  input  logic          two_stop,
  output logic          txd,
  output logic          busy,
  output logic          done_p
);
  localparam int FW = DW + 4;
  localparam int IW = $clog2(FW + 1);
  localparam int CW = $clog2(OVS);

  logic [FW-1:0] sh, sh_n, frame;
  logic [IW-1:0] idx, idx_n, last, last_n, stopi, stopi_n;
  logic [IW-1:0] total, stop_idx;
  logic [CW-1:0] cnt, cnt_n;
  logic          busy_n;

  always_comb begin
    frame         = '1;
    frame[0]      = 1'b0;
    frame[DW:1]   = data;
    if (nine) frame[DW+1] = bit9;
    stop_idx = IW'(DW + 1) + IW'(nine);
    total    = stop_idx + IW'(1) + IW'(two_stop);
  end

  always_comb begin
    sh_n    = sh;
    busy_n  = busy;
    idx_n   = idx;
    cnt_n   = cnt;
    last_n  = last;
    stopi_n = stopi;
    done_p  = 1'b0;
    if (!busy) begin
      if (load) begin
        sh_n    = frame;
        busy_n  = 1'b1;
        idx_n   = '0;
        cnt_n   = '0;
        last_n  = total;
        stopi_n = stop_idx;
      end
    end else if (tick) begin
      if (cnt == CW'(OVS - 1)) begin
        cnt_n = '0;
        sh_n  = {1'b1, sh[FW-1:1]};
        idx_n = idx + 1'b1;
        if (idx_n == stopi) done_p = 1'b1;
        if (idx_n == last)  busy_n = 1'b0;
      end else begin
        cnt_n = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '1;
      busy  <= 1'b0;
      idx   <= '0;
      cnt   <= '0;
      last  <= '0;
      stopi <= '0;
    end else begin
      sh    <= sh_n;
      busy  <= busy_n;
      idx   <= idx_n;
      cnt   <= cnt_n;
      last  <= last_n;
      stopi <= stopi_n;
    end
  end

  assign txd = ~busy | sh[0];
endmodule

// File: rtl/sport_rx.sv
module sport_rx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          rxd_s,
  input  logic          nine,
  output logic          done_p,
  output logic [DW-1:0] data,
  output logic          bit9
);
  import sport_pkg::*;
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW + 2);

  rx_state_e     st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [BW-1:0] bits, bits_n, nbits;
  logic [DW:0]   sh, sh_n;
  logic          nine_q, nine_n;

  assign nbits = nine_q ? BW'(DW + 1) : BW'(DW);

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    bits_n = bits;
    sh_n   = sh;
    nine_n = nine_q;
    done_p = 1'b0;
    if (!en) begin
      st_n = RX_IDLE;
    end else if (tick) begin
      case (st)
        RX_IDLE: if (!rxd_s) begin
          st_n   = RX_START;
          cnt_n  = '0;
          nine_n = nine;
        end
        RX_START: begin
          if (rxd_s) st_n = RX_IDLE;
          else if (cnt == CW'(OVS / 2 - 2)) begin
            st_n   = RX_DATA;
            cnt_n  = '0;
            bits_n = '0;
          end else cnt_n = cnt + 1'b1;
        end
        RX_DATA: begin
          if (cnt == CW'(OVS - 1)) begin
            cnt_n  = '0;
            sh_n   = {rxd_s, sh[DW:1]};
            bits_n = bits + 1'b1;
            if (bits_n == nbits) st_n = RX_STOP;
          end else cnt_n = cnt + 1'b1;
        end
        default: begin
          if (cnt == CW'(OVS - 1)) begin
            done_p = 1'b1;
            st_n   = RX_IDLE;
          end else cnt_n = cnt + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RX_IDLE;
      cnt    <= '0;
      bits   <= '0;
      sh     <= '0;
      nine_q <= 1'b0;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      bits   <= bits_n;
      sh     <= sh_n;
      nine_q <= nine_n;
    end
  end

  assign data = nine_q ? sh[DW-1:0] : sh[DW:1];
  assign bit9 = nine_q & sh[DW];
endmodule

// File: rtl/duplex_sport.sv
module duplex_sport #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rate_tick16,
  input  logic          rxd,
  output logic          txd
);
  import sport_pkg::*;

  logic [1:0]    cfg_mode, cfg_mode_n;
  logic          cfg_dbl, cfg_dbl_n, cfg_two, cfg_two_n, cfg_b9, cfg_b9_n;
  logic          st_tx_done, st_tx_done_n, st_rx_full, st_rx_full_n;
  logic          st_ovr, st_ovr_n, rx_b9, rx_b9_n;
  logic [DW-1:0] rx_buf, rx_buf_n;
  logic          rx_s1, rx_s2;
  logic          tick, tx_busy, tx_done_p, rx_done_p, rx_bit9;
  logic [DW-1:0] rx_data;
  logic          wr_data, wr_ctrl, wr_stat;
  logic          clr_done, clr_full, clr_ovr;

  assign wr_data  = bus_wr && (bus_addr == ADDR_DATA);
  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_stat  = bus_wr && (bus_addr == ADDR_STAT);
  assign clr_done = wr_stat & bus_wdata[0];
  assign clr_full = wr_stat & bus_wdata[1];
  assign clr_ovr  = wr_stat & bus_wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
    end
  end

  sport_tick #(.OVS(OVS)) u_tick (
    .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .dbl(cfg_dbl),
    .ext_tick(rate_tick16), .tick(tick)
  );

  sport_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .load(wr_data && (cfg_mode != MODE_OFF)), .data(bus_wdata),
    .nine(cfg_mode[1]), .bit9(cfg_b9), .two_stop(cfg_two),
    .txd(txd), .busy(tx_busy), .done_p(tx_done_p)
  );

  sport_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(cfg_mode != MODE_OFF),
    .rxd_s(rx_s2), .nine(cfg_mode[1]), .done_p(rx_done_p),
    .data(rx_data), .bit9(rx_bit9)
  );

  always_comb begin
    cfg_mode_n   = cfg_mode;
    cfg_dbl_n    = cfg_dbl;
    cfg_two_n    = cfg_two;
    cfg_b9_n     = cfg_b9;
    st_tx_done_n = st_tx_done;
    st_rx_full_n = st_rx_full;
    st_ovr_n     = st_ovr;
    rx_buf_n     = rx_buf;
    rx_b9_n      = rx_b9;
    if (wr_ctrl) begin
      cfg_mode_n = bus_wdata[1:0];
      cfg_dbl_n  = bus_wdata[2];
      cfg_two_n  = bus_wdata[3];
      cfg_b9_n   = bus_wdata[4];
    end
    if (clr_done) st_tx_done_n = 1'b0;
    if (clr_full) st_rx_full_n = 1'b0;
    if (clr_ovr)  st_ovr_n     = 1'b0;
    if (tx_done_p) st_tx_done_n = 1'b1;
    if (rx_done_p) begin
      if (st_rx_full) st_ovr_n = 1'b1;
      else begin
        st_rx_full_n = 1'b1;
        rx_buf_n     = rx_data;
        rx_b9_n      = rx_bit9;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_mode   <= MODE_OFF;
      cfg_dbl    <= 1'b0;
      cfg_two    <= 1'b0;
      cfg_b9     <= 1'b0;
      st_tx_done <= 1'b0;
      st_rx_full <= 1'b0;
      st_ovr     <= 1'b0;
      rx_buf     <= '0;
      rx_b9      <= 1'b0;
    end else begin
      cfg_mode   <= cfg_mode_n;
      cfg_dbl    <= cfg_dbl_n;
      cfg_two    <= cfg_two_n;
      cfg_b9     <= cfg_b9_n;
      st_tx_done <= st_tx_done_n;
      st_rx_full <= st_rx_full_n;
      st_ovr     <= st_ovr_n;
      rx_buf     <= rx_buf_n;
      rx_b9      <= rx_b9_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_DATA: bus_rdata = rx_buf;
      ADDR_CTRL: bus_rdata[4:0] = {cfg_b9, cfg_two, cfg_dbl, cfg_mode};
      ADDR_STAT: bus_rdata[4:0] = {tx_busy, rx_b9, st_ovr, st_rx_full, st_tx_done};
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sport_chk.sv
module sport_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          txd,
  input logic          tx_busy,
  input logic          tx_done,
  input logic          rx_full,
  input logic [DW-1:0] rx_buf,
  input logic [1:0]    mode,
  input logic          clr_done,
  input logic          clr_full
);
  AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd); // R2
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !clr_done) |=> tx_done); // R7
  AST_DONE_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> (txd && tx_busy)); // R7
  AST_OFF_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !tx_busy) |=> !tx_busy); // R12
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !clr_full) |=> rx_full); // R8
  AST_BUF_KEPT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !clr_full) |=> $stable(rx_buf)); // R10
endmodule

bind duplex_sport sport_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy),
  .tx_done(st_tx_done), .rx_full(st_rx_full), .rx_buf(rx_buf),
  .mode(cfg_mode), .clr_done(clr_done), .clr_full(clr_full)
);

// File: tb/duplex_sport_tb.sv
module duplex_sport_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 3;
  localparam int PER  = 16 * TDIV;

  logic       clk, rst_n, bus_wr, rate_tick16, rxd, txd;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  int nchk, nerr;
  bit finished;
  logic [11:0] cap_bits, cap_done, cap_busy;

  duplex_sport u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rate_tick16(rate_tick16),
    .rxd(rxd), .txd(txd)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    rate_tick16 = 1'b0;
    forever begin
      repeat (TDIV - 1) @(negedge clk);
      rate_tick16 = 1'b1;
      @(negedge clk);
      rate_tick16 = 1'b0;
    end
  end

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd2;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = 2'd2;
  endtask

  function automatic logic [11:0] frame(logic [7:0] d, bit nine, bit b9);
    logic [11:0] f;
    f = '1;
    f[0] = 1'b0;
    f[8:1] = d;
    if (nine) f[9] = b9;
    return f;
  endfunction

  task automatic tx_capture(int nb, int per, int skew);
    cap_bits = '1; cap_done = '0; cap_busy = '0;
    bus_addr = 2'd2;
    repeat (per / 2 - skew) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      #1;
      cap_bits[k] = txd;
      cap_done[k] = bus_rdata[0];
      cap_busy[k] = bus_rdata[4];
      if (k < nb - 1) repeat (per) @(negedge clk);
    end
  endtask

  task automatic rx_send(logic [7:0] d, bit nine, bit b9, int per);
    logic [11:0] f;
    f = frame(d, nine, b9);
    for (int k = 0; k < (nine ? 11 : 10); k++) begin
      @(negedge clk);
      rxd = f[k];
      repeat (per - 1) @(negedge clk);
    end
  endtask

  task automatic gap();
    repeat (2 * PER) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 txd idle", txd, 1);
    bus_read(2'd2, v); chk("R1 status", v, 0);
    bus_read(2'd0, v); chk("R1 data", v, 0);
  endtask

  task automatic t_mode1_tx();
    logic [7:0] v;
    bus_write(2'd1, 8'h01);
    bus_write(2'd2, 8'h07);
    bus_write(2'd0, 8'hA5);
    tx_capture(10, PER, 0);
    chk("R2 mode1 frame", cap_bits[9:0], frame(8'hA5, 0, 0) & 12'h3FF);
    chk("R7 done clear in last data bit", cap_done[8], 0);
    chk("R7 done set at stop bit", cap_done[9], 1);
    gap();
    bus_read(2'd2, v); chk("R7 done still set", v[0], 1);
    bus_write(2'd2, 8'h01);
    bus_read(2'd2, v); chk("R7 done cleared", v[0], 0);
    bus_read(2'd0, v); chk("R3 read returns rx buffer", v, 0);
  endtask

  task automatic t_busy_ignore();
    bus_write(2'd0, 8'h3C);
    bus_write(2'd0, 8'hFF);
    tx_capture(10, PER, 1);
    chk("R13 write while busy ignored", cap_bits[9:0], frame(8'h3C, 0, 0) & 12'h3FF);
    gap();
  endtask

  task automatic t_mode3_tx();
    bus_write(2'd1, 8'h13);
    bus_write(2'd0, 8'h0F);
    tx_capture(11, PER, 0);
    chk("R4 mode3 ninth=1", cap_bits[10:0], frame(8'h0F, 1, 1) & 12'h7FF);
    gap();
    bus_write(2'd1, 8'h03);
    bus_write(2'd0, 8'hF0);
    tx_capture(11, PER, 0);
    chk("R4 mode3 ninth=0", cap_bits[10:0], frame(8'hF0, 1, 0) & 12'h7FF);
    gap();
  endtask

  task automatic t_mode2_rate();
    bus_write(2'd1, 8'h02);
    bus_write(2'd0, 8'h96);
    tx_capture(11, 64, 0);
    chk("R5 mode2 clk/64", cap_bits[10:0], frame(8'h96, 1, 0) & 12'h7FF);
    repeat (128) @(negedge clk);
    bus_write(2'd1, 8'h16);
    bus_write(2'd0, 8'h4D);
    tx_capture(11, 32, 0);
    chk("R5 mode2 clk/32", cap_bits[10:0], frame(8'h4D, 1, 1) & 12'h7FF);
    repeat (96) @(negedge clk);
  endtask

  task automatic t_two_stop();
    bus_write(2'd1, 8'h09);
    bus_write(2'd0, 8'h55);
    tx_capture(12, PER, 0);
    chk("R6 two stop busy in 2nd stop", cap_busy[10], 1);
    chk("R6 two stop idle after", cap_busy[11], 0);
    chk("R6 line high in 2nd stop", cap_bits[10], 1);
    gap();
    bus_write(2'd1, 8'h01);
    bus_write(2'd0, 8'h55);
    tx_capture(11, PER, 0);
    chk("R6 one stop busy in stop", cap_busy[9], 1);
    chk("R6 one stop idle after", cap_busy[10], 0);
    gap();
  endtask

  task automatic t_rx_mode1();
    logic [7:0] v;
    bus_write(2'd2, 8'h07);
    fork
      rx_send(8'h5A, 0, 0, PER);
      begin
        repeat (9 * PER + 1) @(negedge clk);
        bus_read(2'd2, v); chk("R8 full not yet at stop start", v[1], 0);
      end
    join
    bus_read(2'd2, v); chk("R8 full set", v[1], 1);
    bus_read(2'd0, v); chk("R8 rx byte", v, 8'h5A);
    bus_write(2'd2, 8'h02);
    bus_read(2'd2, v); chk("R8 full cleared", v[1], 0);
  endtask

  task automatic t_rx_mode3();
    logic [7:0] v;
    bus_write(2'd1, 8'h03);
    rx_send(8'h81, 1, 1, PER);
    bus_read(2'd2, v); chk("R8 mode3 ninth bit", v[3], 1);
    bus_read(2'd0, v); chk("R8 mode3 byte", v, 8'h81);
    bus_write(2'd2, 8'h02);
    bus_write(2'd1, 8'h01);
  endtask

  task automatic t_glitch();
    logic [7:0] v;
    @(negedge clk); rxd = 1'b0;
    repeat (4 * TDIV) @(negedge clk);
    rxd = 1'b1;
    gap();
    bus_read(2'd2, v); chk("R9 glitch rejected", v[1], 0);
    rx_send(8'h33, 0, 0, PER);
    bus_read(2'd0, v); chk("R9 frame after glitch", v, 8'h33);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    rx_send(8'hCC, 0, 0, PER);
    bus_read(2'd2, v); chk("R10 overrun set", v[2], 1);
    bus_read(2'd0, v); chk("R10 old byte kept", v, 8'h33);
    bus_write(2'd2, 8'h07);
    bus_read(2'd2, v); chk("R10 overrun cleared", v[2:0], 0);
  endtask

  task automatic t_duplex();
    logic [7:0] v;
    fork
      begin
        bus_write(2'd0, 8'h6B);
        tx_capture(10, PER, 0);
      end
      rx_send(8'h94, 0, 0, PER);
    join
    chk("R11 duplex tx", cap_bits[9:0], frame(8'h6B, 0, 0) & 12'h3FF);
    bus_read(2'd0, v); chk("R11 duplex rx", v, 8'h94);
    gap();
    bus_write(2'd2, 8'h07);
  endtask

  task automatic t_mode0();
    logic [7:0] v;
    bus_write(2'd1, 8'h00);
    bus_write(2'd0, 8'h00);
    tx_capture(3, PER, 0);
    chk("R12 mode0 line high", cap_bits[2:0], 3'b111);
    bus_read(2'd2, v); chk("R12 mode0 not busy", v[4], 0);
  endtask

  initial begin
    nchk = 0; nerr = 0; finished = 0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd2; bus_wdata = '0; rxd = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_mode1_tx();
    t_busy_ignore();
    t_mode3_tx();
    t_mode2_rate();
    t_two_stop();
    t_rx_mode1();
    t_rx_mode3();
    t_glitch();
    t_overrun();
    t_duplex();
    t_mode0();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule